// File: doc/BRIEF.md
# Deferred-Exception Poison Tag Tracker

This block keeps one poison tag per general register and maintains it for code that hoists loads above the branches guarding them. A speculative load that would fault does not trap; it tags its destination register instead. The tag flows into every result computed from a tagged source. The exception is raised only when a tagged value reaches a point that needs it: a check operation, which turns it into a redirect to a fix-up address, or a non-speculative consumer such as a store, which reports the exception at that first use. Register data, the memory access and the recovery code sit elsewhere.

Several operations arrive per cycle on parallel issue lanes. Lane 0 is the oldest in program order. All lanes of one cycle read the tags as they stood before that cycle, and when two lanes write the same register the younger lane's tag is kept. The whole tag vector is always visible on an output and can be replaced in one cycle, so an operating system can save and restore it on a context switch.

Top module: `poison_tracker`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears every tag and holds `redirect_valid` and `exc_raise` low.
- R2: A speculative load (kind code 1) sets its destination's tag in the next cycle when `op_fault` is high or its address register (`op_src_a`) is tagged, and raises no exception.
- R3: A speculative load with `op_fault` low and a clean address register clears its destination's tag, exactly as a normal load would.
- R4: A computing operation (kind code 2) gives its destination the OR of the tags of `op_src_a` and `op_src_b`.
- R5: A non-speculative write of a clean result (kind code 3) clears its destination's tag.
- R6: A check (kind code 4) on a tagged `op_src_a` raises `redirect_valid` for its lane in the next cycle, with `redirect_target` equal to that lane's `op_fixup`; on a clean register it falls through with `redirect_valid` low; it never changes a tag.
- R7: A store (kind code 5) raises `exc_raise` for its lane in the next cycle when `op_src_a` (address) or `op_src_b` (data) is tagged, and not otherwise; it changes no tag.
- R8: When several lanes of one cycle write the same register, the tag written by the highest-numbered lane is kept.
- R9: Every lane reads the tag vector as it stood at the start of the cycle; a write by an older lane in the same cycle is not seen.
- R10: While `restore_en` is high the tag vector becomes `restore_vec` in the next cycle and every lane operation of that cycle is ignored, producing neither a tag change nor a redirect nor an exception.
- R11: `poison_vec` shows the current tag of register i on bit i at all times.
- R12: A lane with `op_valid` low, or with an unused kind code (0, 6, 7), has no effect on tags or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 2 | Per-lane operation present |
| op_kind | input | 6 | Per-lane kind code, 3 bits per lane |
| op_dst | input | 14 | Per-lane destination register, 7 bits per lane |
| op_src_a | input | 14 | Per-lane first source (address for loads and stores) |
| op_src_b | input | 14 | Per-lane second source (data for stores) |
| op_fault | input | 2 | Per-lane: the speculative load's access would fault |
| op_fixup | input | 64 | Per-lane fix-up address for checks, 32 bits per lane |
| restore_en | input | 1 | Replace the whole tag vector |
| restore_vec | input | 128 | Tag vector to load |
| poison_vec | output | 128 | Current tag vector, for saving |
| redirect_valid | output | 2 | Per-lane check found a tagged register |
| redirect_target | output | 64 | Per-lane fix-up address of the redirect |
| exc_raise | output | 2 | Per-lane store consumed a tagged register |

## Verification
The hardest situations are those inside a single cycle: two lanes naming the same destination, and a younger lane reading a register that an older lane is rewriting, where write ordering and start-of-cycle reads interact. Directed bundles set a register's tag first and then issue both lanes against it in both orders, and a long random phase draws registers from a small pool so that such collisions, tag chains through computing operations and restores with live operations recur often, all compared every clock against a behavioural model.

// File: rtl/poison_pkg.sv
// Shared definitions for the poison tag tracker.
// Assumes: kind codes not listed here are treated as no operation.
package poison_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_SLOAD = 3'd1,
        OP_ALU   = 3'd2,
        OP_CLEAN = 3'd3,
        OP_CHECK = 3'd4,
        OP_STORE = 3'd5
    } op_kind_e;

endpackage

// File: rtl/poison_lane_eval.sv
// Evaluates one issue lane against the tag vector as it stood at the
// start of the cycle. Produces the lane's tag write request and its
// redirect / exception requests. Purely combinational.
// Assumes: the caller gates the lane off during a restore via `block`.
module poison_lane_eval
    import poison_pkg::*;
#(
    parameter int NREGS  = 128,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              valid,
    input  logic [2:0]        kind,
    input  logic [IDX_W-1:0]  dst,
    input  logic [IDX_W-1:0]  src_a,
    input  logic [IDX_W-1:0]  src_b,
    input  logic              fault,
    input  logic [ADDR_W-1:0] fixup,
    input  logic              block,
    input  logic [NREGS-1:0]  tags,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_val,
    output logic              redir,
    output logic [ADDR_W-1:0] redir_tgt,
    output logic              exc
);

    logic tag_a;
    logic tag_b;
    logic live;

    // Look up the source tags from the pre-cycle vector.
    always_comb begin
        tag_a = tags[src_a];
        tag_b = tags[src_b];
        live  = valid && !block;
    end

    // Decode the lane's kind into write, redirect and exception requests.
    always_comb begin
        wr_en     = 1'b0;
        wr_idx    = dst;
        wr_val    = 1'b0;
        redir     = 1'b0;
        redir_tgt = '0;
        exc       = 1'b0;
        if (live) begin
            case (op_kind_e'(kind))
                OP_SLOAD: begin
                    wr_en  = 1'b1;
                    wr_val = fault | tag_a;
                end
                OP_ALU: begin
                    wr_en  = 1'b1;
                    wr_val = tag_a | tag_b;
                end
                OP_CLEAN: begin
                    wr_en  = 1'b1;
                    wr_val = 1'b0;
                end
                OP_CHECK: begin
                    redir     = tag_a;
                    redir_tgt = tag_a ? fixup : '0;
                end
                OP_STORE: begin
                    exc = tag_a | tag_b;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/poison_state.sv
// Holds the per-register poison tags. Applies the lane writes in
// program order (lane 0 first, so the youngest lane wins) or replaces
// the whole vector on a restore.
// Assumes: lane writes are already suppressed during a restore.
module poison_state #(
    parameter int NREGS = 128,
    parameter int LANES = 2,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       wr_en,
    input  logic [LANES*IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0]       wr_val,
    input  logic                   restore_en,
    input  logic [NREGS-1:0]       restore_vec,
    output logic [NREGS-1:0]       tags_q
);

    logic [NREGS-1:0] tags_d;

    // Merge the lane writes in program order, then let a restore override.
    always_comb begin
        tags_d = tags_q;
        for (int l = 0; l < LANES; l++) begin
            if (wr_en[l]) tags_d[wr_idx[l*IDX_W +: IDX_W]] = wr_val[l];
        end
        if (restore_en) tags_d = restore_vec;
    end

    // Tag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tags_q <= '0;
        else        tags_q <= tags_d;
    end

    // R10
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(restore_en) |-> tags_q == $past(restore_vec));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(restore_en) && !$past(|wr_en) |-> $stable(tags_q));

endmodule

// File: rtl/poison_event_reg.sv
// Registers the per-lane redirect and exception requests so that they
// appear one cycle after the operation issues.
// Assumes: targets are zero for lanes that do not redirect.
module poison_event_reg #(
    parameter int LANES  = 2,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        redir_d,
    input  logic [LANES*ADDR_W-1:0] tgt_d,
    input  logic [LANES-1:0]        exc_d,
    output logic [LANES-1:0]        redir_q,
    output logic [LANES*ADDR_W-1:0] tgt_q,
    output logic [LANES-1:0]        exc_q
);

    // Event register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_q <= '0;
            tgt_q   <= '0;
            exc_q   <= '0;
        end else begin
            redir_q <= redir_d;
            tgt_q   <= tgt_d;
            exc_q   <= exc_d;
        end
    end

endmodule

// File: rtl/poison_tracker.sv
// Poison tag tracker: one tag per general register, set by faulting
// speculative loads, propagated through computations, turned into a
// redirect by a check and into an exception by a store.
// Assumes: lane 0 is oldest in program order; all lanes read the
// start-of-cycle tags; events appear one cycle after issue.
module poison_tracker
    import poison_pkg::*;
#(
    parameter int NREGS  = 128,
    parameter int LANES  = 2,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        op_valid,
    input  logic [LANES*3-1:0]      op_kind,
    input  logic [LANES*IDX_W-1:0]  op_dst,
    input  logic [LANES*IDX_W-1:0]  op_src_a,
    input  logic [LANES*IDX_W-1:0]  op_src_b,
    input  logic [LANES-1:0]        op_fault,
    input  logic [LANES*ADDR_W-1:0] op_fixup,
    input  logic                    restore_en,
    input  logic [NREGS-1:0]        restore_vec,
    output logic [NREGS-1:0]        poison_vec,
    output logic [LANES-1:0]        redirect_valid,
    output logic [LANES*ADDR_W-1:0] redirect_target,
    output logic [LANES-1:0]        exc_raise
);

    logic [NREGS-1:0]        tags_q;
    logic [LANES-1:0]        wr_en;
    logic [LANES*IDX_W-1:0]  wr_idx;
    logic [LANES-1:0]        wr_val;
    logic [LANES-1:0]        redir_d;
    logic [LANES*ADDR_W-1:0] tgt_d;
    logic [LANES-1:0]        exc_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        poison_lane_eval #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_eval (
            .valid     (op_valid[g]),
            .kind      (op_kind[g*3 +: 3]),
            .dst       (op_dst[g*IDX_W +: IDX_W]),
            .src_a     (op_src_a[g*IDX_W +: IDX_W]),
            .src_b     (op_src_b[g*IDX_W +: IDX_W]),
            .fault     (op_fault[g]),
            .fixup     (op_fixup[g*ADDR_W +: ADDR_W]),
            .block     (restore_en),
            .tags      (tags_q),
            .wr_en     (wr_en[g]),
            .wr_idx    (wr_idx[g*IDX_W +: IDX_W]),
            .wr_val    (wr_val[g]),
            .redir     (redir_d[g]),
            .redir_tgt (tgt_d[g*ADDR_W +: ADDR_W]),
            .exc       (exc_d[g])
        );

        // R6
        redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            redirect_valid[g] |-> $past(rst_n) && $past(op_valid[g]) && !$past(restore_en)
                && $past(op_kind[g*3 +: 3]) == 3'(OP_CHECK)
                && $past(tags_q[op_src_a[g*IDX_W +: IDX_W]]));

        // R6
        redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            redirect_valid[g] |-> redirect_target[g*ADDR_W +: ADDR_W]
                == $past(op_fixup[g*ADDR_W +: ADDR_W]));

        // R7
        exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            exc_raise[g] |-> $past(rst_n) && $past(op_valid[g]) && !$past(restore_en)
                && $past(op_kind[g*3 +: 3]) == 3'(OP_STORE)
                && ($past(tags_q[op_src_a[g*IDX_W +: IDX_W]])
                    || $past(tags_q[op_src_b[g*IDX_W +: IDX_W]])));
    end

    poison_state #(.NREGS(NREGS), .LANES(LANES)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val),
        .restore_en  (restore_en),
        .restore_vec (restore_vec),
        .tags_q      (tags_q)
    );

    poison_event_reg #(.LANES(LANES), .ADDR_W(ADDR_W)) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .redir_d (redir_d),
        .tgt_d   (tgt_d),
        .exc_d   (exc_d),
        .redir_q (redirect_valid),
        .tgt_q   (redirect_target),
        .exc_q   (exc_raise)
    );

    // Expose the live tag vector for context save.
    always_comb poison_vec = tags_q;

    // R10
    restore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(restore_en) |-> redirect_valid == '0 && exc_raise == '0);

endmodule

// File: tb/poison_tracker_tb.sv
// Bench: behavioural tag model compared against the design on every clock.
module poison_tracker_tb;

    localparam int NR = 128;
    localparam int NL = 2;
    localparam int IW = 7;
    localparam int AW = 32;

    localparam logic [2:0] K_NOP = 3'd0, K_SLD = 3'd1, K_ALU = 3'd2,
                           K_CLN = 3'd3, K_CHK = 3'd4, K_STO = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     op_valid = '0;
    logic [NL*3-1:0]   op_kind = '0;
    logic [NL*IW-1:0]  op_dst = '0;
    logic [NL*IW-1:0]  op_src_a = '0;
    logic [NL*IW-1:0]  op_src_b = '0;
    logic [NL-1:0]     op_fault = '0;
    logic [NL*AW-1:0]  op_fixup = '0;
    logic              restore_en = 1'b0;
    logic [NR-1:0]     restore_vec = '0;
    logic [NR-1:0]     poison_vec;
    logic [NL-1:0]     redirect_valid;
    logic [NL*AW-1:0]  redirect_target;
    logic [NL-1:0]     exc_raise;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [NR-1:0] model = '0;

    always #5 clk = ~clk;

    poison_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
        .op_fault(op_fault), .op_fixup(op_fixup), .restore_en(restore_en),
        .restore_vec(restore_vec), .poison_vec(poison_vec),
        .redirect_valid(redirect_valid), .redirect_target(redirect_target),
        .exc_raise(exc_raise)
    );

    task automatic clear_ops();
        op_valid = '0; op_kind = '0; op_dst = '0; op_src_a = '0;
        op_src_b = '0; op_fault = '0; op_fixup = '0; restore_en = 1'b0;
    endtask

    task automatic set_lane(int l, logic [2:0] k, int d, int a, int b,
                            logic f, logic [AW-1:0] fx);
        op_valid[l]            = 1'b1;
        op_kind[l*3 +: 3]      = k;
        op_dst[l*IW +: IW]     = IW'(d);
        op_src_a[l*IW +: IW]   = IW'(a);
        op_src_b[l*IW +: IW]   = IW'(b);
        op_fault[l]            = f;
        op_fixup[l*AW +: AW]   = fx;
    endtask

    // Apply the current inputs for one clock and compare every output.
    task automatic step(string tag);
        logic [NR-1:0]    nxt;
        logic [NL-1:0]    e_r, e_x;
        logic [NL*AW-1:0] e_t;
        nxt = model; e_r = '0; e_x = '0; e_t = '0;
        if (restore_en) nxt = restore_vec;
        else begin
            for (int l = 0; l < NL; l++) begin
                int d, a, b;
                d = int'(op_dst[l*IW +: IW]);
                a = int'(op_src_a[l*IW +: IW]);
                b = int'(op_src_b[l*IW +: IW]);
                if (op_valid[l]) begin
                    if (op_kind[l*3 +: 3] == K_SLD) nxt[d] = op_fault[l] | model[a];
                    else if (op_kind[l*3 +: 3] == K_ALU) nxt[d] = model[a] | model[b];
                    else if (op_kind[l*3 +: 3] == K_CLN) nxt[d] = 1'b0;
                    else if (op_kind[l*3 +: 3] == K_CHK && model[a]) begin
                        e_r[l] = 1'b1; e_t[l*AW +: AW] = op_fixup[l*AW +: AW];
                    end else if (op_kind[l*3 +: 3] == K_STO && (model[a] | model[b]))
                        e_x[l] = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        model = nxt;
        checks++;
        if (poison_vec !== model) begin
            errors++;
            $display("FAIL %s poison_vec act=%h exp=%h", tag, poison_vec, model);
        end
        if (redirect_valid !== e_r) begin
            errors++;
            $display("FAIL %s redirect_valid act=%b exp=%b", tag, redirect_valid, e_r);
        end
        if (exc_raise !== e_x) begin
            errors++;
            $display("FAIL %s exc_raise act=%b exp=%b", tag, exc_raise, e_x);
        end
        for (int l = 0; l < NL; l++) begin
            if (e_r[l] && redirect_valid[l] &&
                redirect_target[l*AW +: AW] !== e_t[l*AW +: AW]) begin
                errors++;
                $display("FAIL %s redirect_target lane %0d act=%h exp=%h", tag, l,
                         redirect_target[l*AW +: AW], e_t[l*AW +: AW]);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        checks++;
        if (poison_vec !== '0 || redirect_valid !== '0 || exc_raise !== '0) begin
            errors++;
            $display("FAIL R1 reset act=%h/%b/%b exp=0", poison_vec, redirect_valid, exc_raise);
        end

        clear_ops(); set_lane(0, K_SLD, 5, 1, 0, 1'b1, 0);          step("R2");
        clear_ops(); set_lane(0, K_SLD, 9, 5, 0, 1'b0, 0);          step("R2");
        clear_ops(); set_lane(0, K_STO, 0, 2, 5, 1'b0, 0);
                     set_lane(1, K_STO, 0, 2, 6, 1'b0, 0);          step("R7");
        clear_ops(); set_lane(1, K_STO, 0, 9, 3, 1'b0, 0);          step("R7");
        clear_ops(); set_lane(0, K_CHK, 0, 6, 0, 1'b0, 32'h1111);
                     set_lane(1, K_CHK, 0, 5, 0, 1'b0, 32'h1234);   step("R6");
        clear_ops(); set_lane(0, K_ALU, 7, 6, 5, 1'b0, 0);
                     set_lane(1, K_ALU, 8, 6, 4, 1'b0, 0);          step("R4");
        clear_ops(); set_lane(0, K_SLD, 5, 2, 0, 1'b0, 0);          step("R3");
        clear_ops(); set_lane(0, K_CLN, 7, 0, 0, 1'b0, 0);          step("R5");
        clear_ops(); set_lane(0, K_SLD, 10, 0, 0, 1'b1, 0);
                     set_lane(1, K_CLN, 10, 0, 0, 1'b0, 0);         step("R8");
        clear_ops(); set_lane(0, K_CLN, 10, 0, 0, 1'b0, 0);
                     set_lane(1, K_SLD, 10, 0, 0, 1'b1, 0);         step("R8");
        clear_ops(); set_lane(0, K_CLN, 10, 0, 0, 1'b0, 0);
                     set_lane(1, K_CHK, 0, 10, 0, 1'b0, 32'hABCD);  step("R9");
        clear_ops(); set_lane(0, K_SLD, 0, 0, 0, 1'b1, 0);
                     set_lane(1, K_SLD, 127, 0, 0, 1'b1, 0);        step("R2");
        clear_ops(); restore_en = 1'b1; restore_vec = {64'h00F0_0000_0000_0001, 64'h8000_0000_0000_0010};
                     set_lane(0, K_SLD, 3, 0, 0, 1'b1, 0);
                     set_lane(1, K_CHK, 0, 127, 0, 1'b0, 32'h55);   step("R10");
        clear_ops(); set_lane(0, K_SLD, 20, 0, 0, 1'b1, 0); op_valid = '0;
                     set_lane(1, 3'd6, 21, 0, 0, 1'b1, 0);          step("R12");
        clear_ops(); set_lane(0, K_STO, 0, 4, 127, 1'b0, 0);
                     set_lane(1, K_CHK, 0, 64, 0, 1'b0, 32'h77);    step("R11");

        // R11: long mixed run over a small register pool
        for (int i = 0; i < 3000; i++) begin
            clear_ops();
            for (int l = 0; l < NL; l++) begin
                op_valid[l]          = ($urandom % 4) != 0;
                op_kind[l*3 +: 3]    = 3'($urandom % 8);
                op_dst[l*IW +: IW]   = IW'($urandom % 8);
                op_src_a[l*IW +: IW] = IW'($urandom % 8);
                op_src_b[l*IW +: IW] = IW'($urandom % 8);
                op_fault[l]          = ($urandom % 3) == 0;
                op_fixup[l*AW +: AW] = $urandom;
            end
            restore_en = ($urandom % 32) == 0;
            restore_vec = {$urandom, $urandom, $urandom, $urandom};
            step("R11");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule